// File: doc/BRIEF.md
# Timer Overflow and Capture Interrupt Logic

This block watches the counts of two free-running 16-bit timers and turns their wrap points into interrupt requests and status flags. An increment strobe marks the cycle in which both counts have just advanced. Timer 1 overflows when an increment brings its count to zero. Timer 2 overflows at two points: zero and the half-range value 8000H. A legacy overflow request is shared by both timers and gated by one enable bit per timer. Timer 2 also drives a dedicated overflow request that needs no enable.

A status byte records which timer overflowed. The flags stay set until software reads the byte, and the read strobe clears them. A separate capture pin is synchronised through two flops. Each rising edge latches the timer 2 count and pulses a capture request.

Top module: `tmr_ovf_cap_irq`

## Requirements
- R1: When `inc_stb` is high and `t1_cnt` is 0000H, status bit 5 is set at the next clock edge, whatever the enables are.
- R2: When `inc_stb` is high and `t2_cnt` is 0000H or 8000H, status bit 4 is set and `irq_t2_ovf` pulses high for one cycle after the next clock edge. Neither depends on the enables. Other counts such as 7FFFH, 8001H and FFFFH raise nothing.
- R3: `irq_ovf` pulses for one cycle after the next edge if timer 1 overflows with `en_t1_ovf` high, or if timer 2 overflows with `en_t2_ovf` high. It stays low otherwise.
- R4: Without `inc_stb`, a count sitting at a boundary value raises no request and sets no flag.
- R5: Status bits 4 and 5 are sticky and are cleared by the edge on which `stat_rd` is high. A flag set on that same edge survives. All other status bits read 0.
- R6: A rising edge on `cap_pin` goes through two synchroniser flops and is detected one cycle later. On the third clock edge after the pin is first sampled high, `cap_val` takes the `t2_cnt` value and `irq_cap` pulses for one cycle.
- R7: Between captures `cap_val` holds its value. Holding the pin high, or a falling edge, causes no capture.
- R8: Reset (`rst_n` low) clears all requests, the status byte and `cap_val` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_stb | input | 1 | Counts have just advanced this cycle |
| t1_cnt | input | 16 | Timer 1 count |
| t2_cnt | input | 16 | Timer 2 count |
| en_t1_ovf | input | 1 | Enables timer 1 on the shared request |
| en_t2_ovf | input | 1 | Enables timer 2 on the shared request |
| cap_pin | input | 1 | Asynchronous capture pin |
| stat_rd | input | 1 | Status byte read strobe (clear on read) |
| irq_ovf | output | 1 | Shared overflow request pulse |
| irq_t2_ovf | output | 1 | Dedicated timer 2 overflow pulse |
| irq_cap | output | 1 | Capture request pulse |
| cap_val | output | 16 | Captured timer 2 count |
| status | output | 8 | Bit 5 timer 1 overflowed, bit 4 timer 2 overflowed |

## Verification
The overflow detectors are driven with a vector table that pairs each boundary value with the counts next to it (7FFFH, 8001H, FFFFH). This separates a correct two-point timer 2 compare from a single-point or half-masked compare. The table also sweeps the enable combinations, so the shared request's gating can be told apart from the ungated dedicated request and the ungated status flags. Some vectors hold a boundary count with the strobe low, which catches level-style detection. Directed sequences cover a read that coincides with a new overflow, and capture edges, held levels and falling edges on the pin with a changing timer 2 count.

// File: rtl/tmr_ovf_cap_irq.sv
module tmr_ovf_cap_irq #(
  parameter int CNT_W   = 16,
  parameter int STAT_W  = 8,
  parameter int T1_BIT  = 5,
  parameter int T2_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_stb,
  input  logic [CNT_W-1:0]  t1_cnt,
  input  logic [CNT_W-1:0]  t2_cnt,
  input  logic              en_t1_ovf,
  input  logic              en_t2_ovf,
  input  logic              cap_pin,
  input  logic              stat_rd,
  output logic              irq_ovf,
  output logic              irq_t2_ovf,
  output logic              irq_cap,
  output logic [CNT_W-1:0]  cap_val,
  output logic [STAT_W-1:0] status
);

  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  logic t1_wrap, t2_wrap;
  logic t1_flag, t2_flag;
  logic [2:0] pin_sh;
  logic cap_edge;

  assign t1_wrap  = inc_stb && (t1_cnt == '0);
  assign t2_wrap  = inc_stb && ((t2_cnt == '0) || (t2_cnt == HALF));
  assign cap_edge = pin_sh[1] & ~pin_sh[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ovf    <= 1'b0;
      irq_t2_ovf <= 1'b0;
      t1_flag    <= 1'b0;
      t2_flag    <= 1'b0;
    end else begin
      irq_ovf    <= (t1_wrap && en_t1_ovf) || (t2_wrap && en_t2_ovf);
      irq_t2_ovf <= t2_wrap;
      t1_flag    <= t1_wrap || (t1_flag && !stat_rd);
      t2_flag    <= t2_wrap || (t2_flag && !stat_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh  <= '0;
      irq_cap <= 1'b0;
      cap_val <= '0;
    end else begin
      pin_sh  <= {pin_sh[1:0], cap_pin};
      irq_cap <= cap_edge;
      if (cap_edge) cap_val <= t2_cnt;
    end
  end

  always_comb begin
    status         = '0;
    status[T1_BIT] = t1_flag;
    status[T2_BIT] = t2_flag;
  end

  // R1
  p_t1_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_stb && t1_cnt == '0) |=> status[T1_BIT]);
  // R2
  p_t2_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_stb && (t2_cnt == '0 || t2_cnt == HALF)) |=> (irq_t2_ovf && status[T2_BIT]));
  // R3
  p_shared_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_t1_ovf && !en_t2_ovf) |=> !irq_ovf);
  // R4
  p_no_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_stb |=> (!irq_ovf && !irq_t2_ovf));
  // R5
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[T1_BIT] && !stat_rd) |=> status[T1_BIT]);
  // R6
  p_cap_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cap |=> !irq_cap);
  // R7
  p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_cap |-> $stable(cap_val));

endmodule

// File: tb/tmr_ovf_cap_irq_tb.sv
`timescale 1ns/1ps
module tmr_ovf_cap_irq_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic inc_stb = 0, en_t1_ovf = 0, en_t2_ovf = 0, cap_pin = 0, stat_rd = 0;
  logic [15:0] t1_cnt = 16'h0001, t2_cnt = 16'h0001;
  logic irq_ovf, irq_t2_ovf, irq_cap;
  logic [15:0] cap_val;
  logic [7:0] status;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tmr_ovf_cap_irq u_dut (
    .clk(clk), .rst_n(rst_n), .inc_stb(inc_stb), .t1_cnt(t1_cnt), .t2_cnt(t2_cnt),
    .en_t1_ovf(en_t1_ovf), .en_t2_ovf(en_t2_ovf), .cap_pin(cap_pin), .stat_rd(stat_rd),
    .irq_ovf(irq_ovf), .irq_t2_ovf(irq_t2_ovf), .irq_cap(irq_cap),
    .cap_val(cap_val), .status(status)
  );

  // {inc, t1, t2, en1, en2, exp_shared, exp_t2irq, exp_st5, exp_st4}
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 16'h0000, 16'h0005, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b1, 16'h0000, 16'h0005, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 16'h0007, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {1'b1, 16'h0007, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 16'h0000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b1, 16'h0003, 16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 16'h0003, 16'h8001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    inc_stb = 0; stat_rd = 0; t1_cnt = 16'h0001; t2_cnt = 16'h0001;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 status", status, 0);
    chk("R8 irqs", {irq_ovf, irq_t2_ovf, irq_cap}, 0);
    chk("R8 cap_val", cap_val, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      {inc_stb, t1_cnt, t2_cnt, en_t1_ovf, en_t2_ovf} = VEC[i][38:4];
      @(negedge clk);
      chk("R3 shared irq", irq_ovf, VEC[i][3]);
      chk("R2 t2 irq", irq_t2_ovf, VEC[i][2]);
      chk("R1 status bit5", status[5], VEC[i][1]);
      chk("R2 status bit4", status[4], VEC[i][0]);
      chk("R4/R5 other bits", {status[7:6], status[3:0]}, 0);
      idle(); stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
      chk("R5 cleared", status, 0);
    end

    // R5 sticky across idle cycles
    inc_stb = 1; t1_cnt = 0; en_t1_ovf = 0; en_t2_ovf = 0;
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    chk("R5 sticky", status, 8'h20);
    chk("R3 gated off", irq_ovf, 0);
    // R5 set wins over concurrent clear
    inc_stb = 1; t2_cnt = 16'h8000; stat_rd = 1;
    @(negedge clk);
    idle();
    chk("R5 set with read", status, 8'h10);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    chk("R5 read clears", status, 0);

    // R6 capture latency and value
    t2_cnt = 16'h1234;
    cap_pin = 1;
    @(negedge clk);
    chk("R6 no irq after sample", irq_cap, 0);
    @(negedge clk);
    chk("R6 no irq after sync", irq_cap, 0);
    @(negedge clk);
    chk("R6 irq_cap", irq_cap, 1);
    chk("R6 cap_val", cap_val, 16'h1234);
    t2_cnt = 16'h5555;
    @(negedge clk);
    chk("R6 one-cycle pulse", irq_cap, 0);
    // R7 held high and falling edge
    repeat (4) @(negedge clk);
    chk("R7 held high no capture", {irq_cap, cap_val}, {1'b0, 16'h1234});
    cap_pin = 0;
    repeat (4) @(negedge clk);
    chk("R7 falling edge no capture", {irq_cap, cap_val}, {1'b0, 16'h1234});
    // R6 second capture updates value
    t2_cnt = 16'hABCD;
    cap_pin = 1;
    repeat (3) @(negedge clk);
    chk("R6 second capture", {irq_cap, cap_val}, {1'b1, 16'hABCD});
    cap_pin = 0;
    repeat (4) @(negedge clk);
    chk("R7 hold after capture", cap_val, 16'hABCD);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule